// File: doc/BRIEF.md
# GPIO bank with interrupt sensing

This block is one bank of thirty-two general-purpose pins behind a small memory-mapped register file. Software decides per line whether the line is a plain input, a driven output or an interrupt source. Interrupt sources sense a high level, a low level, a rising edge, a falling edge or, when the bank is built with that option, any edge. Detected events are latched in a pending register and gated by a per-line enable mask. All enabled pending lines are merged into one interrupt request.

The bus is a plain synchronous port. A write happens on the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr`, so it is valid in the same cycle. Pad inputs are brought into the clock domain by a two-flop synchroniser. A third flop keeps the previous synchronised value for edge detection. A filter-enable register is kept only as storage for software. Pin multiplexing and power control are handled elsewhere.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every stored register, the pending register and the mask read as zero, `pad_oe` is zero and `irq` is low.
- R2: `pad_oe` bit i is 1 exactly when mode bit i (offset 0x00) is 0 and direction bit i (offset 0x04, 1 = output) is 1. `pad_out` carries the output-data register (offset 0x08).
- R3: The polarity register (offset 0x20) is shared by both uses. In all modes it inverts `pad_out` bit by bit. It also inverts the value read from the input-data register at offset 0x0C.
- R4: Level sensing is selected when the mode bit is 1 and the edge bit (offset 0x24) is 0. Polarity 0 means active high and polarity 1 means active low. The pending bit follows the active level, so a write-1 clear has no lasting effect while the level stays active.
- R5: Edge sensing is selected when the mode bit is 1 and the edge bit is 1. Polarity 0 senses a rising edge and polarity 1 senses a falling edge. The pending bit stays set until it is cleared.
- R6: With the both-edge bit (offset 0x4C) set on an edge line, either transition sets pending, whatever the polarity bit holds. When the parameter `BOTH_EDGE_EN` is 0, offset 0x4C reads zero.
- R7: Writing 1s to offset 0x14 clears those pending bits of edge lines, and 0 bits have no effect. An edge event in the same cycle as the clear wins.
- R8: A write to offset 0x18 clears the mask bits that are written 0 and keeps the others. A write to offset 0x1C sets the mask bits that are written 1. Offset 0x18 reads the mask.
- R9: `irq` is high exactly when some line has both its pending bit and its mask bit set.
- R10: A line in general I/O mode (mode bit 0) has its pending bit at zero one cycle after the mode is in effect.
- R11: Offsets 0x00, 0x04, 0x08, 0x20, 0x24, 0x28 and 0x4C read back what was last written. Offset 0x10 reads pending. Offsets 0x14, 0x1C and unmapped offsets read zero.
- R12: A pad change is visible at offset 0x0C after two clock edges, and in the pending register after three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 7 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Asynchronous pad inputs |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| irq | output | 1 | Merged interrupt request |

## Verification
Register writes take effect at the write edge. The bench therefore samples read data, `pad_out`, `pad_oe`, the mask and `irq` just after the next falling edge. A pad change made at a falling edge appears at offset 0x0C after two rising edges and in pending after three. The bench checks both the cycle before and the cycle of each change, so a result that arrives one edge early or late is reported. The same-cycle clear test places the clear write on exactly the third edge after a pad rise, where the edge event lands.

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int LINES = 32,
  parameter int AW = 7,
  parameter bit BOTH_EDGE_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [LINES-1:0] bus_wdata,
  output logic [LINES-1:0] bus_rdata,
  input  logic [LINES-1:0] pad_in,
  output logic [LINES-1:0] pad_out,
  output logic [LINES-1:0] pad_oe,
  output logic             irq
);
  localparam logic [AW-1:0] A_MODE   = AW'('h00);
  localparam logic [AW-1:0] A_DIR    = AW'('h04);
  localparam logic [AW-1:0] A_OUT    = AW'('h08);
  localparam logic [AW-1:0] A_IN     = AW'('h0C);
  localparam logic [AW-1:0] A_PEND   = AW'('h10);
  localparam logic [AW-1:0] A_CLR    = AW'('h14);
  localparam logic [AW-1:0] A_MASK   = AW'('h18);
  localparam logic [AW-1:0] A_UNMASK = AW'('h1C);
  localparam logic [AW-1:0] A_POL    = AW'('h20);
  localparam logic [AW-1:0] A_EDGE   = AW'('h24);
  localparam logic [AW-1:0] A_FILT   = AW'('h28);
  localparam logic [AW-1:0] A_BOTH   = AW'('h4C);

  logic [LINES-1:0] mode_q, dir_q, out_q, pol_q, edge_q, filt_q, both_q, mask_q, pend_q;
  logic [LINES-1:0] s1_q, s2_q, s3_q;
  logic [LINES-1:0] level_act, rise, fall, edge_ev, clr, pend_d;

  wire wr_at_clr = bus_wr && (bus_addr == A_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; dir_q <= '0; out_q <= '0; pol_q <= '0;
      edge_q <= '0; filt_q <= '0; mask_q <= '0; pend_q <= '0;
      s1_q <= '0; s2_q <= '0; s3_q <= '0;
    end else begin
      s1_q <= pad_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
      pend_q <= pend_d;
      if (bus_wr) begin
        case (bus_addr)
          A_MODE:   mode_q <= bus_wdata;
          A_DIR:    dir_q  <= bus_wdata;
          A_OUT:    out_q  <= bus_wdata;
          A_POL:    pol_q  <= bus_wdata;
          A_EDGE:   edge_q <= bus_wdata;
          A_FILT:   filt_q <= bus_wdata;
          A_MASK:   mask_q <= mask_q & bus_wdata;
          A_UNMASK: mask_q <= mask_q | bus_wdata;
          default: ;
        endcase
      end
    end
  end

  generate
    if (BOTH_EDGE_EN) begin : g_both
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) both_q <= '0;
        else if (bus_wr && (bus_addr == A_BOTH)) both_q <= bus_wdata;
      end
    end else begin : g_no_both
      assign both_q = '0;
    end
  endgenerate

  assign level_act = s2_q ^ pol_q;
  assign rise      = s2_q & ~s3_q;
  assign fall      = ~s2_q & s3_q;
  assign edge_ev   = (both_q & (rise | fall)) |
                     (~both_q & ((~pol_q & rise) | (pol_q & fall)));
  assign clr       = wr_at_clr ? bus_wdata : '0;
  assign pend_d    = mode_q & ((~edge_q & level_act) |
                               (edge_q & ((pend_q & ~clr) | edge_ev)));

  assign irq     = |(pend_q & mask_q);
  assign pad_oe  = ~mode_q & dir_q;
  assign pad_out = out_q ^ pol_q;

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = mode_q;
      A_DIR:   bus_rdata = dir_q;
      A_OUT:   bus_rdata = out_q;
      A_IN:    bus_rdata = s2_q ^ pol_q;
      A_PEND:  bus_rdata = pend_q;
      A_MASK:  bus_rdata = mask_q;
      A_POL:   bus_rdata = pol_q;
      A_EDGE:  bus_rdata = edge_q;
      A_FILT:  bus_rdata = filt_q;
      A_BOTH:  bus_rdata = both_q;
      default: bus_rdata = '0;
    endcase
  end

  // R7: a clear without a coincident event leaves the edge pending bit low
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_at_clr |=> ((pend_q & $past(bus_wdata & mode_q & edge_q & ~edge_ev)) == '0));

  // R8: a mask write never enables a line
  p_mask_noset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MASK) |=> ((mask_q & ~$past(mask_q)) == '0));

  // R8: an unmask write enables every line it names
  p_unmask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_UNMASK) |=> (($past(bus_wdata) & ~mask_q) == '0));

  // R10: general I/O lines hold no pending state
  p_gpio_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(mode_q)) == '0));

  // R9: the request needs an enabled line
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0));

  // R4: level lines track the previous cycle's active level
  p_level_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(mode_q & ~edge_q)) == $past(level_act & mode_q & ~edge_q)));

  // R5: an edge pending bit drops only through a clear
  p_edge_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pend_q & mode_q & edge_q & ~clr) & ~pend_q) == '0));
endmodule

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, nb_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe, nb_out, nb_oe;
  logic        irq, nb_irq;
  int vecs = 0;
  int miss = 0;

  always #4 clk = ~clk;

  gpio_irq_bank u_dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq(irq));

  gpio_irq_bank #(.BOTH_EDGE_EN(1'b0)) u_dut_nb (.clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(nb_rdata),
    .pad_in(pad_in), .pad_out(nb_out), .pad_oe(nb_oe), .irq(nb_irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; #1;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  initial begin
    #(8 * 150000);
    miss++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [6:0] regs [7];
    regs = '{7'h00, 7'h04, 7'h08, 7'h20, 7'h24, 7'h28, 7'h4C};
    step(2);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    for (int a = 0; a < 'h50; a += 4) begin
      rd(7'(a), d);
      chk("R1 reset read", d, 32'h0);
    end
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R11 readback
    foreach (regs[k]) begin
      logic [31:0] v;
      v = 32'h9C00_0001 ^ ({25'h0, regs[k]} * 32'h0101_0101);
      wr(regs[k], v);
      rd(regs[k], d);
      chk("R11 readback", d, v);
      wr(regs[k], 32'h0);
    end
    foreach (regs[k]) ;
    rd(7'h14, d); chk("R11 clear reads zero", d, 32'h0);
    rd(7'h1C, d); chk("R11 unmask reads zero", d, 32'h0);
    rd(7'h30, d); chk("R11 unmapped reads zero", d, 32'h0);

    // R6 parameter off: both-edge register reads zero
    wr(7'h4C, 32'hFFFF_FFFF);
    bus_addr = 7'h4C; #1;
    chk("R6 both-edge off reads zero", nb_rdata, 32'h0);
    chk("R6 both-edge on readback", bus_rdata, 32'hFFFF_FFFF);
    wr(7'h4C, 32'h0);

    // R2 direction and output sweep
    wr(7'h08, 32'h1234_5678);
    for (int i = 0; i < 32; i++) begin
      wr(7'h04, 32'h1 << i);
      chk("R2 pad_oe per line", pad_oe, 32'h1 << i);
      chk("R2 pad_out", pad_out, 32'h1234_5678);
    end
    wr(7'h04, 32'hFFFF_FFFF);
    wr(7'h00, 32'h00FF_00FF);
    chk("R2 interrupt lines not driven", pad_oe, 32'hFF00_FF00);
    wr(7'h00, 32'h0);
    // R3 output inversion
    wr(7'h20, 32'h0000_FFFF);
    chk("R3 pad_out inverted", pad_out, 32'h1234_5678 ^ 32'h0000_FFFF);
    wr(7'h20, 32'h0); wr(7'h04, 32'h0);

    // R12 / R3 input sync latency and inversion
    pad_in = 32'hA5A5_0F0F;
    step(1);
    rd(7'h0C, d); chk("R12 input after one edge", d, 32'h0);
    step(1);
    rd(7'h0C, d); chk("R12 input after two edges", d, 32'hA5A5_0F0F);
    wr(7'h20, 32'hFFFF_0000);
    rd(7'h0C, d); chk("R3 input inverted", d, 32'hA5A5_0F0F ^ 32'hFFFF_0000);
    wr(7'h20, 32'h0);
    pad_in = 32'h0;
    step(4);

    // R4 R5 R6 interrupt kind sweep: 0 lvl hi, 1 lvl lo, 2 rise, 3 fall, 4 both
    for (int k = 0; k < 5; k++) begin
      int L;
      logic [31:0] b, e0, er, ec, ef;
      L = 3 + k * 6;
      b = 32'h1 << L;
      e0 = (k == 1) ? b : 32'h0;
      er = (k == 0 || k == 2 || k == 4) ? b : 32'h0;
      ec = (k == 0) ? b : 32'h0;
      ef = (k == 1 || k == 3 || k == 4) ? b : 32'h0;
      wr(7'h20, (k == 1 || k == 3) ? b : 32'h0);
      wr(7'h24, (k >= 2) ? b : 32'h0);
      wr(7'h4C, (k == 4) ? b : 32'h0);
      wr(7'h00, b);
      wr(7'h1C, b);
      step(3);
      wr(7'h14, b);
      rd(7'h10, d);
      if (k < 2) chk("R4 level pending at baseline", d, e0);
      else chk("R5 edge idle", d, e0);
      pad_in[L] = 1'b1;
      step(2);
      rd(7'h10, d); chk("R12 pending not yet after two edges", d, e0);
      step(1);
      rd(7'h10, d);
      if (k == 4) chk("R6 both-edge rise", d, er);
      else if (k < 2) chk("R4 level after rise", d, er);
      else chk("R5 edge after rise", d, er);
      chk("R9 irq after rise", {31'h0, irq}, {31'h0, |er});
      wr(7'h14, b);
      rd(7'h10, d);
      if (k < 2) chk("R4 clear ignored while active", d, ec);
      else chk("R7 clear edge pending", d, ec);
      pad_in[L] = 1'b0;
      step(3);
      rd(7'h10, d);
      if (k == 4) chk("R6 both-edge fall", d, ef);
      else if (k < 2) chk("R4 level after fall", d, ef);
      else chk("R5 edge after fall", d, ef);
      chk("R9 irq after fall", {31'h0, irq}, {31'h0, |ef});
      wr(7'h14, b);
      wr(7'h00, 32'h0);
      wr(7'h18, 32'h0);
      wr(7'h20, 32'h0); wr(7'h24, 32'h0); wr(7'h4C, 32'h0);
      step(1);
    end

    // R8 mask register
    wr(7'h1C, 32'hF0F0_0000);
    rd(7'h18, d); chk("R8 unmask sets", d, 32'hF0F0_0000);
    wr(7'h18, 32'hFFFF_0000);
    rd(7'h18, d); chk("R8 mask write keeps ones", d, 32'hF0F0_0000);
    wr(7'h18, 32'h3000_FFFF);
    rd(7'h18, d); chk("R8 mask write clears zeros", d, 32'h3000_0000);
    wr(7'h18, 32'h0);

    // R9 / R7 with a rising-edge line 30
    wr(7'h24, 32'h4000_0000);
    wr(7'h00, 32'h4000_0000);
    pad_in[30] = 1'b1;
    step(3);
    rd(7'h10, d); chk("R5 pending held with mask off", d, 32'h4000_0000);
    chk("R9 irq low while masked", {31'h0, irq}, 32'h0);
    wr(7'h1C, 32'h4000_0000);
    chk("R9 irq high after unmask", {31'h0, irq}, 32'h1);
    wr(7'h14, 32'hBFFF_FFFF);
    rd(7'h10, d); chk("R7 zero bits no effect", d, 32'h4000_0000);
    wr(7'h14, 32'h4000_0000);
    rd(7'h10, d); chk("R7 clear", d, 32'h0);
    chk("R9 irq low after clear", {31'h0, irq}, 32'h0);
    pad_in[30] = 1'b0;
    step(4);
    pad_in[30] = 1'b1;
    step(2);
    wr(7'h14, 32'h4000_0000);
    rd(7'h10, d); chk("R7 event wins over same-cycle clear", d, 32'h4000_0000);

    // R10 leaving interrupt mode drops pending
    wr(7'h00, 32'h0);
    step(1);
    rd(7'h10, d); chk("R10 pending zero in GPIO mode", d, 32'h0);
    chk("R10 irq low", {31'h0, irq}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule